// File: doc/BRIEF.md
# Power-Management Event and SCI Controller

This block keeps the first-level power-management event state of a system: a status register that latches wake and timer events, an enable register that selects which latched events may interrupt, a control register, and a free-running power-management timer. It raises a level-sensitive system control interrupt (SCI) while any enabled interrupt source has its status latched. Software clears a latched event by writing a one to its status bit.

The registers appear in a 64-byte byte-addressed I/O window. Two configuration values place that window: a base dword, of which only the 64-byte-aligned part of the low word counts, and an enable byte whose bit 0 switches decoding on. An access inside the decoded window is claimed through `io_claim`. An access outside the window, or any access while decoding is off, is left unclaimed and changes nothing.

The timer counts cycles of a tick-enable input. Each time its most significant bit changes value, an overflow event occurs, and that event latches the timer status bit while the timer is armed.

Top module: `pm_event_ctrl`

## Requirements
- R1: The window base is `cfg_base & 32'h0000FFC0`. An access is claimed only when `io_addr & 16'hFFC0` equals that base, which covers 64 bytes. `io_rdata` is 0 whenever the access is not claimed.
- R2: The window is decoded only while bit 0 of `cfg_enable` is 1. Writes that are not claimed change no register.
- R3: After reset the status, enable and control registers and the timer count are all zero, and `sci` is low.
- R4: The status register sits at window offsets 0x00 (low byte) and 0x01 (high byte), enable at 0x02/0x03, control at 0x04/0x05, and the timer at 0x08..0x0B, least significant byte first. Enable and control read back the bytes written to them. Every other offset in the window reads 0 and ignores writes.
- R5: The status bits are timer bit 0, global lock bit 5, power button bit 8 and RTC alarm bit 10. All other status bits read 0. A rising edge on an event input sets its status bit whatever the enable register holds. An input held high sets its bit only once.
- R6: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. When an event sets a bit in the same cycle that a write clears it, the bit ends up set.
- R7: `sci` is high exactly when status AND enable has one of bits 0, 5, 8 or 10 set. It follows each status or enable change in the cycle after the write or event edge. Enable bits outside those four never raise `sci`.
- R8: The timer is a `TMR_W`-bit counter (24 by default) that adds one on each clock with `tick` high and wraps to zero. It reads zero-extended to 32 bits. Writes to its bytes are ignored.
- R9: When the top timer bit changes value, timer status bit 0 is set only if enable bit 0 is 1. With enable bit 0 clear, the change leaves the status bit clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | 32 | Configuration base dword for the I/O window |
| cfg_enable | input | 8 | Configuration enable byte; bit 0 turns decoding on |
| io_addr | input | 16 | Byte address of the I/O access |
| io_wr | input | 1 | Write strobe, one byte per cycle |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational, 0 when unclaimed |
| io_claim | output | 1 | The access falls in the decoded window |
| tick | input | 1 | Timer advance enable |
| ev_pwrbtn | input | 1 | Power button event level |
| ev_rtc | input | 1 | RTC alarm event level |
| ev_glock | input | 1 | Global lock release event level |
| sci | output | 1 | Level-sensitive system control interrupt |

## Verification
A table of byte reads and writes covers each register offset, the read-only timer bytes, an unused offset, the last byte of the window and the addresses just outside it on both sides. A mismatch there separates a wrong offset map from a wrong window bound. Each event source is pulsed once with its enable set and once with it clear. These cases separate the latching of status, which ignores enable, from the gating of `sci`. Further cases hold an input high across a clear, so that level triggering shows up, and collide an event edge with its clearing write, so that a wrong priority shows up. The timer is stepped to exactly one tick before and one tick after its top bit changes, with the timer armed and disarmed. A different base with unaligned low bits checks the masking.

// File: rtl/pm_event_pkg.sv
// Package: shared constants of the power-management event controller.
// Assumes a 64-byte window and 16-bit event registers.
package pm_event_pkg;
    localparam int WIN_BITS  = 6;
    localparam int REG_W     = 16;

    // Status/enable bit positions of the interrupt sources
    localparam int BIT_TMR   = 0;
    localparam int BIT_GLK   = 5;
    localparam int BIT_PWR   = 8;
    localparam int BIT_RTC   = 10;

    localparam logic [REG_W-1:0] SRC_MASK =
        REG_W'((1 << BIT_TMR) | (1 << BIT_GLK) | (1 << BIT_PWR) | (1 << BIT_RTC));

    // Window offsets (low byte of each register)
    localparam logic [WIN_BITS-1:0] OFS_STS = 6'h00;
    localparam logic [WIN_BITS-1:0] OFS_EN  = 6'h02;
    localparam logic [WIN_BITS-1:0] OFS_CTL = 6'h04;
    localparam logic [WIN_BITS-1:0] OFS_TMR = 6'h08;

    // External event inputs: count and their status positions
    localparam int NUM_EV = 3;
    typedef enum logic [1:0] { EV_PWR = 2'd0, EV_RTC = 2'd1, EV_GLK = 2'd2 } ev_idx_e;

    function automatic int ev_bit(input int idx);
        case (idx)
            0:       return BIT_PWR;
            1:       return BIT_RTC;
            default: return BIT_GLK;
        endcase
    endfunction
endpackage

// File: rtl/pm_window_decode.sv
// Module: pm_window_decode
// Decides whether an I/O byte address falls in the power-management window
// and yields the offset inside it. Base alignment comes from WIN_BITS; the
// window is decoded only while bit 0 of the enable byte is set.
module pm_window_decode
    import pm_event_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [31:0]         cfg_base,
    input  logic [7:0]          cfg_enable,
    input  logic [ADDR_W-1:0]   addr,
    output logic                hit,
    output logic [WIN_BITS-1:0] offset
);
    localparam logic [31:0]       BASE_MASK = 32'((1 << ADDR_W) - (1 << WIN_BITS));
    localparam logic [ADDR_W-1:0] ADDR_MASK = ADDR_W'(BASE_MASK);

    logic [31:0] base_aligned;
    logic        dec_on;

    // Compare the aligned address with the aligned base when decoding is on
    always_comb begin
        base_aligned = cfg_base & BASE_MASK;
        dec_on       = (cfg_enable & 8'h01) != 8'h00;
        hit          = dec_on && (32'(addr & ADDR_MASK) == base_aligned);
        offset       = addr[WIN_BITS-1:0];
    end
endmodule

// File: rtl/pm_timer.sv
// Module: pm_timer
// Free-running TMR_W-bit up-counter advanced by a tick enable. Emits a
// one-cycle overflow pulse whenever its top bit changes value.
// Assumes 2 <= TMR_W <= 32.
module pm_timer #(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [TMR_W-1:0] count,
    output logic             overflow
);
    logic [TMR_W-1:0] count_nx;

    // Next count and top-bit change detection
    always_comb begin
        count_nx = count + 1'b1;
        overflow = tick && (count[TMR_W-1] != count_nx[TMR_W-1]);
    end

    // Count register
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (tick) count <= count_nx;
    end

    // R8
    tick_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (count == $past(count) + 1'b1));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));
endmodule

// File: rtl/pm_event_regs.sv
// Module: pm_event_regs
// Holds the status (write-one-to-clear), enable and control registers,
// latches rising edges of the event inputs and the armed timer overflow,
// and drives the SCI level. Assumes event inputs are synchronous to clk.
module pm_event_regs
    import pm_event_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [WIN_BITS-1:0] offset,
    input  logic [7:0]          wdata,
    input  logic                tmr_ovf,
    input  logic [NUM_EV-1:0]   ev_in,
    output logic [REG_W-1:0]    sts,
    output logic [REG_W-1:0]    en,
    output logic [REG_W-1:0]    ctl,
    output logic                sci
);
    logic [NUM_EV-1:0] ev_q;
    logic [NUM_EV-1:0] ev_rise;
    logic [REG_W-1:0]  set_vec;
    logic [REG_W-1:0]  clr_vec;
    logic [REG_W-1:0]  ev_set;
    logic [REG_W-1:0]  sts_nx;

    // Previous event levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_in;
    end

    assign ev_rise = ev_in & ~ev_q;

    // Map each event edge onto its status bit
    generate
        for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
            localparam int POS = ev_bit(g);
            assign ev_set[POS] = ev_rise[g];
        end
        for (genvar b = 0; b < REG_W; b++) begin : g_fill
            if (b != BIT_PWR && b != BIT_RTC && b != BIT_GLK) begin : g_zero
                assign ev_set[b] = 1'b0;
            end
        end
    endgenerate

    // Set vector: event edges plus the armed timer overflow
    always_comb begin
        set_vec = ev_set;
        if (tmr_ovf && en[BIT_TMR]) set_vec[BIT_TMR] = 1'b1;
    end

    // Clear vector from a write-one-to-clear byte access
    always_comb begin
        clr_vec = '0;
        if (wr_en && offset == OFS_STS)          clr_vec[7:0]  = wdata;
        if (wr_en && offset == OFS_STS + 6'd1)   clr_vec[15:8] = wdata;
        sts_nx = ((sts & ~clr_vec) | set_vec) & SRC_MASK;
    end

    // Status register
    always_ff @(posedge clk) begin
        if (!rst_n) sts <= '0;
        else        sts <= sts_nx;
    end

    // Byte-lane writes for enable and control
    generate
        for (genvar ln = 0; ln < REG_W / 8; ln++) begin : g_lane
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    en[8*ln +: 8]  <= '0;
                    ctl[8*ln +: 8] <= '0;
                end else if (wr_en) begin
                    if (offset == OFS_EN + 6'(ln))  en[8*ln +: 8]  <= wdata;
                    if (offset == OFS_CTL + 6'(ln)) ctl[8*ln +: 8] <= wdata;
                end
            end
        end
    endgenerate

    // Interrupt level from enabled latched sources
    assign sci = |(sts & en & SRC_MASK);

    // R5
    pwr_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_in[EV_PWR] && !ev_q[EV_PWR]) |=> sts[BIT_PWR]);

    // R5
    rtc_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_in[EV_RTC] && !ev_q[EV_RTC]) |=> sts[BIT_RTC]);

    // R6
    w1c_tmr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && offset == OFS_STS && wdata[BIT_TMR] && !(tmr_ovf && en[BIT_TMR]))
            |=> !sts[BIT_TMR]);

    // R4
    en_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && offset == OFS_EN) |=> (en[7:0] == $past(wdata)));

    // R9
    disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sts[BIT_TMR] && !en[BIT_TMR]) |=> !sts[BIT_TMR]);
endmodule

// File: rtl/pm_event_ctrl.sv
// Module: pm_event_ctrl (top)
// Power-management event controller: decodes the 64-byte I/O window,
// hosts the event registers and timer, and returns byte read data.
// Assumes one byte access per cycle; read data is combinational.
module pm_event_ctrl
    import pm_event_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int TMR_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cfg_base,
    input  logic [7:0]        cfg_enable,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              io_claim,
    input  logic              tick,
    input  logic              ev_pwrbtn,
    input  logic              ev_rtc,
    input  logic              ev_glock,
    output logic              sci
);
    localparam int TMR_RD_W = 32;

    logic                hit;
    logic [WIN_BITS-1:0] offset;
    logic [TMR_W-1:0]    tmr_count;
    logic                tmr_ovf;
    logic [REG_W-1:0]    sts;
    logic [REG_W-1:0]    en;
    logic [REG_W-1:0]    ctl;
    logic [NUM_EV-1:0]   ev_in;
    logic [TMR_RD_W-1:0] tmr_rd;

    pm_window_decode #(.ADDR_W(ADDR_W)) u_dec (
        .cfg_base   (cfg_base),
        .cfg_enable (cfg_enable),
        .addr       (io_addr),
        .hit        (hit),
        .offset     (offset)
    );

    pm_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .count    (tmr_count),
        .overflow (tmr_ovf)
    );

    // Gather event inputs in package index order
    always_comb begin
        ev_in         = '0;
        ev_in[EV_PWR] = ev_pwrbtn;
        ev_in[EV_RTC] = ev_rtc;
        ev_in[EV_GLK] = ev_glock;
    end

    pm_event_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (hit && io_wr),
        .offset  (offset),
        .wdata   (io_wdata),
        .tmr_ovf (tmr_ovf),
        .ev_in   (ev_in),
        .sts     (sts),
        .en      (en),
        .ctl     (ctl),
        .sci     (sci)
    );

    // Claim any strobed access inside the decoded window
    assign io_claim = hit && (io_rd || io_wr);
    assign tmr_rd   = TMR_RD_W'(tmr_count);

    // Byte read multiplexer
    always_comb begin
        io_rdata = 8'h00;
        if (hit) begin
            unique case (offset)
                OFS_STS:         io_rdata = sts[7:0];
                OFS_STS + 6'd1:  io_rdata = sts[15:8];
                OFS_EN:          io_rdata = en[7:0];
                OFS_EN + 6'd1:   io_rdata = en[15:8];
                OFS_CTL:         io_rdata = ctl[7:0];
                OFS_CTL + 6'd1:  io_rdata = ctl[15:8];
                OFS_TMR:         io_rdata = tmr_rd[7:0];
                OFS_TMR + 6'd1:  io_rdata = tmr_rd[15:8];
                OFS_TMR + 6'd2:  io_rdata = tmr_rd[23:16];
                OFS_TMR + 6'd3:  io_rdata = tmr_rd[31:24];
                default:         io_rdata = 8'h00;
            endcase
        end
    end

    // R2
    claim_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_claim |-> cfg_enable[0]);

    // R1
    claim_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_claim |-> (32'(io_addr & 16'hFFC0) == (cfg_base & 32'h0000FFC0)));

    // R1
    unclaimed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_claim) |-> (io_rdata == 8'h00));
endmodule

// File: tb/pm_event_ctrl_test.sv
module pm_event_ctrl_test;
    localparam int TW = 6;   // short timer so the top bit toggles in 32 ticks

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_base = 32'h0;
    logic [7:0]  cfg_enable = 8'h0;
    logic [15:0] io_addr = 16'h0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = 8'h0;
    logic [7:0]  io_rdata;
    logic        io_claim;
    logic        tick = 1'b0, ev_pwrbtn = 1'b0, ev_rtc = 1'b0, ev_glock = 1'b0;
    logic        sci;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pm_event_ctrl #(.TMR_W(TW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_enable(cfg_enable),
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_claim(io_claim), .tick(tick),
        .ev_pwrbtn(ev_pwrbtn), .ev_rtc(ev_rtc), .ev_glock(ev_glock), .sci(sci)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // One access: drive at negedge, sample combinational result, release next negedge
    task automatic acc(input logic wr, input logic [15:0] a, input logic [7:0] d,
                       output logic [7:0] rd, output logic cl);
        @(negedge clk);
        io_wr = wr; io_rd = !wr; io_addr = a; io_wdata = d;
        #1; rd = io_rdata; cl = io_claim;
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0;
    endtask

    task automatic wr8(input logic [15:0] a, input logic [7:0] d);
        logic [7:0] r; logic c;
        acc(1'b1, a, d, r, c);
    endtask

    task automatic rdchk(input string req, input logic [15:0] a, input logic [7:0] exp);
        logic [7:0] r; logic c;
        acc(1'b0, a, 8'h00, r, c);
        chk(req, r, exp);
    endtask

    task automatic tick_n(input int n);
        @(negedge clk); tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic sci_chk(input string req, input logic exp);
        @(negedge clk); #1;
        chk(req, {7'b0, sci}, {7'b0, exp});
    endtask

    // Vector: {is_wr, addr, wdata, exp_rdata, exp_claim}
    localparam int NV = 18;
    localparam logic [33:0] VEC [NV] = '{
        {1'b0, 16'hB040, 8'h00, 8'h00, 1'b1},  // R4 status low
        {1'b1, 16'hB042, 8'h21, 8'h00, 1'b1},  // R4 enable low
        {1'b0, 16'hB042, 8'h00, 8'h21, 1'b1},
        {1'b1, 16'hB043, 8'h05, 8'h00, 1'b1},  // R4 enable high
        {1'b0, 16'hB043, 8'h00, 8'h05, 1'b1},
        {1'b1, 16'hB044, 8'hA5, 8'h00, 1'b1},  // R4 control low
        {1'b0, 16'hB044, 8'h00, 8'hA5, 1'b1},
        {1'b1, 16'hB045, 8'h3C, 8'h00, 1'b1},  // R4 control high
        {1'b0, 16'hB045, 8'h00, 8'h3C, 1'b1},
        {1'b1, 16'hB048, 8'hFF, 8'h00, 1'b1},  // R8 timer read-only
        {1'b0, 16'hB048, 8'h00, 8'h00, 1'b1},
        {1'b0, 16'hB04B, 8'h00, 8'h00, 1'b1},
        {1'b1, 16'hB07F, 8'h99, 8'h00, 1'b1},  // R4 unused offset
        {1'b0, 16'hB07F, 8'h00, 8'h00, 1'b1},
        {1'b0, 16'hB080, 8'h00, 8'h00, 1'b0},  // R1 past top
        {1'b0, 16'hB03F, 8'h00, 8'h00, 1'b0},  // R1 below base
        {1'b1, 16'hB082, 8'h77, 8'h00, 1'b0},  // R2 unclaimed write
        {1'b0, 16'hB042, 8'h00, 8'h21, 1'b1}   // R2 enable untouched
    };

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] r; logic c;
        cfg_base = 32'h0000_B07F;   // aligned base 0xB040
        repeat (3) @(negedge clk);
        #1; chk("R3 sci at reset", {7'b0, sci}, 8'h00);
        rst_n = 1'b1;

        // R2 disabled window: not claimed
        acc(1'b0, 16'hB040, 8'h00, r, c);
        chk("R2 claim while disabled", {7'b0, c}, 8'h00);
        cfg_enable = 8'hFE;
        acc(1'b0, 16'hB040, 8'h00, r, c);
        chk("R2 claim with bit0 clear", {7'b0, c}, 8'h00);
        cfg_enable = 8'h01;

        // R3 reset values
        rdchk("R3 status", 16'hB041, 8'h00);
        rdchk("R3 enable", 16'hB043, 8'h00);
        rdchk("R3 control", 16'hB045, 8'h00);
        rdchk("R3 timer", 16'hB048, 8'h00);

        for (int i = 0; i < NV; i++) begin
            acc(VEC[i][33], VEC[i][32:17], VEC[i][16:9], r, c);
            chk($sformatf("R1/R4 vec %0d claim", i), {7'b0, c}, {7'b0, VEC[i][0]});
            if (!VEC[i][33]) chk($sformatf("R4 vec %0d data", i), r, VEC[i][8:1]);
        end

        // R7 enable bits outside sources never raise sci
        wr8(16'hB042, 8'hFF); wr8(16'hB043, 8'hFF);
        sci_chk("R7 stray enables", 1'b0);
        wr8(16'hB042, 8'h21); wr8(16'hB043, 8'h05);

        // R5 power button sets bit 8, R7 sci raised
        @(negedge clk); ev_pwrbtn = 1'b1;
        @(negedge clk);
        #1; chk("R7 sci after pwr edge", {7'b0, sci}, 8'h01);
        rdchk("R5 pwr status", 16'hB041, 8'h01);
        // R6 clear while held high; R5 no re-set from level
        wr8(16'hB041, 8'h01);
        repeat (3) @(negedge clk);
        rdchk("R5 held level no reset", 16'hB041, 8'h00);
        sci_chk("R7 sci after clear", 1'b0);
        ev_pwrbtn = 1'b0;

        // R5 RTC edge; R6 write zero keeps it
        @(negedge clk); ev_rtc = 1'b1;
        @(negedge clk); ev_rtc = 1'b0;
        wr8(16'hB041, 8'h00);
        rdchk("R6 write zero keeps", 16'hB041, 8'h04);
        wr8(16'hB041, 8'h04);
        rdchk("R6 rtc cleared", 16'hB041, 8'h00);

        // R6 same-cycle edge and clear: set wins
        @(negedge clk);
        ev_rtc = 1'b1; io_wr = 1'b1; io_addr = 16'hB041; io_wdata = 8'h04;
        @(negedge clk);
        ev_rtc = 1'b0; io_wr = 1'b0;
        rdchk("R6 set beats clear", 16'hB041, 8'h04);
        wr8(16'hB041, 8'hFF);

        // R5 event latched with enable clear; R7 gated then raised by enable
        wr8(16'hB042, 8'h00); wr8(16'hB043, 8'h00);
        @(negedge clk); ev_glock = 1'b1;
        @(negedge clk); ev_glock = 1'b0;
        rdchk("R5 glock with enable clear", 16'hB040, 8'h20);
        sci_chk("R7 sci gated", 1'b0);
        wr8(16'hB042, 8'h20);
        sci_chk("R7 sci on enable write", 1'b1);
        wr8(16'hB040, 8'hFF);
        sci_chk("R7 sci after w1c", 1'b0);

        // R8/R9 timer armed
        wr8(16'hB042, 8'h01);
        tick_n(31);
        rdchk("R9 no status before toggle", 16'hB040, 8'h00);
        tick_n(1);
        rdchk("R9 status on toggle", 16'hB040, 8'h01);
        sci_chk("R7 sci from timer", 1'b1);
        rdchk("R8 timer count", 16'hB048, 8'h20);
        wr8(16'hB040, 8'h01);
        rdchk("R6 timer cleared", 16'hB040, 8'h00);
        // R9 disarmed wrap
        wr8(16'hB042, 8'h00);
        tick_n(32);
        rdchk("R9 disarmed toggle", 16'hB040, 8'h00);
        rdchk("R8 timer wrap", 16'hB048, 8'h00);

        // R1 base masking with unaligned low bits
        cfg_base = 32'h1234_5678;
        acc(1'b0, 16'h5640, 8'h00, r, c);
        chk("R1 new base claim", {7'b0, c}, 8'h01);
        acc(1'b0, 16'h567F, 8'h00, r, c);
        chk("R1 new top claim", {7'b0, c}, 8'h01);
        acc(1'b0, 16'h5680, 8'h00, r, c);
        chk("R1 beyond window", {7'b0, c}, 8'h00);
        chk("R1 unclaimed data", r, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule